// File: doc/BRIEF.md
# Handshake Word Crossing Between Unrelated Clocks

This block carries one multi-bit word at a time from a source clock domain into a destination clock domain whose clock has no fixed relation to the source clock. The data bus itself is never passed through per-bit synchronizers. Only a single request line goes forward and a single acknowledge line comes back, and each goes through a chain of flip-flops clocked by the receiving side. The destination samples the bus only after its synchronized copy of the request has risen. By then the held word has been stable for at least two destination clocks.

The source side accepts a word when `src_ready` is high and `src_send` is pulsed. It then holds that word in a register and raises its request. It drops the request once the returned acknowledge is seen, and it reopens `src_ready` only after the acknowledge has gone low again. The exchange therefore has four phases: request up, acknowledge up, request down, acknowledge down. The destination side turns the rising edge of the synchronized request into a one-cycle `dst_strobe`, which also loads `dst_word`. It drives the acknowledge from that same synchronized copy. Each domain has its own active-low asynchronous reset.

Top module: `bus_handoff`

## Requirements
- R1: After reset, `dst_strobe` is 0, `dst_word` is all zeros and `src_ready` is 1.
- R2: A word is accepted only on a source clock edge where `src_send` and `src_ready` are both 1. From the next source cycle `src_ready` stays 0 until the synchronized acknowledge has fallen back to 0.
- R3: A `src_send` pulse while `src_ready` is 0 is ignored. No extra word is delivered, and the word in flight arrives unchanged.
- R4: Each accepted word produces exactly one `dst_strobe` pulse, one destination cycle wide. In the cycle of that pulse, `dst_word` equals the accepted word.
- R5: Between strobes, `dst_word` keeps its last delivered value.
- R6: Words arrive in the order they were accepted, and none is lost, for any mix of bit patterns and launch gaps.
- R7: While the request is up, the held source word does not change, so the destination never samples a moving bus.
- R8: The acknowledge rises only while the destination's synchronized request is high, and falls only while it is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain reset, active low, asynchronous |
| src_send | input | 1 | Offer `src_word` for transfer on this source edge |
| src_word | input | W | Word to transfer |
| src_ready | output | 1 | High when a new word may be offered |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain reset, active low, asynchronous |
| dst_strobe | output | 1 | One-cycle pulse marking a newly delivered word |
| dst_word | output | W | Last delivered word |

## Verification
The hardest case to reach from the ports is a `src_send` that arrives while a transfer is still in flight. Such a pulse must leave both the held word and the delivery count untouched, yet it only lands inside the handshake window if the stimulus deliberately aims there. The bench therefore launches a word and then fires a few offers with a different value in the source cycles that follow, before `src_ready` returns. The two clocks run at 200 MHz and about 137 MHz, with varying idle gaps, so the strobe falls at many phase offsets. The queue-based model has to match every delivery in value and in order.

// File: rtl/bus_handoff.sv
module bus_handoff #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         src_clk,
  input  logic         src_rst_n,
  input  logic         src_send,
  input  logic [W-1:0] src_word,
  output logic         src_ready,
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  output logic         dst_strobe,
  output logic [W-1:0] dst_word
);

  logic [W-1:0]      src_hold;
  logic              req;
  logic [STAGES-1:0] ack_pipe;
  logic              ack_seen;
  logic              launch;

  logic [STAGES-1:0] req_pipe;
  logic              req_seen;
  logic              req_last;
  logic              ack;
  logic              req_rise;

  assign ack_seen  = ack_pipe[STAGES-1];
  assign src_ready = !req && !ack_seen;
  assign launch    = src_send && src_ready;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      src_hold <= '0;
      req      <= 1'b0;
      ack_pipe <= '0;
    end else begin
      ack_pipe <= {ack_pipe[STAGES-2:0], ack};
      if (launch) begin
        src_hold <= src_word;
        req      <= 1'b1;
      end else if (req && ack_seen) begin
        req <= 1'b0;
      end
    end
  end

  assign req_seen = req_pipe[STAGES-1];
  assign req_rise = req_seen && !req_last;
  assign ack      = req_last;

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      req_pipe   <= '0;
      req_last   <= 1'b0;
      dst_strobe <= 1'b0;
      dst_word   <= '0;
    end else begin
      req_pipe   <= {req_pipe[STAGES-2:0], req};
      req_last   <= req_seen;
      dst_strobe <= req_rise;
      if (req_rise) dst_word <= src_hold;
    end
  end

endmodule

module bus_handoff_chk #(
  parameter int W = 16
) (
  input logic         src_clk,
  input logic         src_rst_n,
  input logic         src_send,
  input logic         src_ready,
  input logic         req,
  input logic         ack_seen,
  input logic [W-1:0] src_hold,
  input logic         dst_clk,
  input logic         dst_rst_n,
  input logic         dst_strobe,
  input logic [W-1:0] dst_word,
  input logic         req_seen,
  input logic         ack
);

  // R2
  launch_gate_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    $rose(req) |-> $past(!ack_seen));

  // R3
  busy_ignore_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (src_send && !src_ready) |=> $stable(src_hold));

  // R7
  hold_stable_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    req |=> $stable(src_hold));

  // R4
  single_pulse_chk: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    dst_strobe |=> !dst_strobe);

  // R4
  capture_match_chk: assert property (@(posedge dst_clk) disable iff (!dst_rst_n || !src_rst_n)
    dst_strobe |-> dst_word == src_hold);

  // R5
  word_keep_chk: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    !dst_strobe |-> $stable(dst_word));

  // R8
  ack_rise_chk: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    $rose(ack) |-> req_seen);

  // R8
  ack_fall_chk: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    $fell(ack) |-> !req_seen);

endmodule

bind bus_handoff bus_handoff_chk #(.W(W)) chk (
  .src_clk(src_clk), .src_rst_n(src_rst_n), .src_send(src_send),
  .src_ready(src_ready), .req(req), .ack_seen(ack_seen), .src_hold(src_hold),
  .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .dst_strobe(dst_strobe),
  .dst_word(dst_word), .req_seen(req_seen), .ack(ack)
);

// File: tb/bus_handoff_test.sv
`timescale 1ns/1ps
module bus_handoff_test;
  localparam int W = 16;

  logic         src_clk = 0, dst_clk = 0;
  logic         src_rst_n = 0, dst_rst_n = 0;
  logic         src_send = 0;
  logic [W-1:0] src_word = '0;
  logic         src_ready, dst_strobe;
  logic [W-1:0] dst_word;

  int total = 0, bad = 0;
  int launched = 0, delivered = 0;
  logic [W-1:0] expq[$];
  logic [W-1:0] last_word = '0;

  always #2.5  src_clk = ~src_clk;
  always #3.65 dst_clk = ~dst_clk;

  bus_handoff #(.W(W)) uut (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_send(src_send),
    .src_word(src_word), .src_ready(src_ready),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
    .dst_strobe(dst_strobe), .dst_word(dst_word)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge dst_clk) begin
    if (dst_rst_n && src_rst_n) begin
      if (dst_strobe) begin
        delivered++;
        if (expq.size() == 0)
          check(0, "R4 extra strobe", dst_word, '0);
        else
          check(dst_word == expq.pop_front(), "R6 order/value", dst_word, dst_word ^ 16'h0);
        last_word = dst_word;
      end else if (dst_word != last_word) begin
        check(0, "R5 word kept", dst_word, last_word);
      end
    end
  end

  task automatic send_word(input logic [W-1:0] w, input int busy_pokes);
    @(negedge src_clk);
    while (!src_ready) @(negedge src_clk);
    src_word = w;
    src_send = 1;
    expq.push_back(w);
    launched++;
    @(negedge src_clk);
    src_send = 0;
    check(src_ready == 0, "R2 ready drops", {15'd0, src_ready}, '0);
    for (int i = 0; i < busy_pokes; i++) begin
      src_word = ~w;
      src_send = 1;
      @(negedge src_clk);
      src_send = 0;
      check(src_ready == 0, "R3 busy stays", {15'd0, src_ready}, '0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge src_clk);
    check(0, "watchdog", '0, '1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge src_clk);
    src_rst_n = 1;
    dst_rst_n = 1;
    repeat (3) @(negedge dst_clk);
    check(dst_strobe == 0, "R1 strobe", {15'd0, dst_strobe}, '0);
    check(dst_word == '0, "R1 word", dst_word, '0);
    check(src_ready == 1, "R1 ready", {15'd0, src_ready}, 16'd1);

    send_word(16'h0000, 0);
    send_word(16'hFFFF, 0);
    send_word(16'hA5A5, 3);
    send_word(16'h5A5A, 6);
    for (int k = 0; k < 40; k++) begin
      send_word(W'($urandom), k % 4);
      repeat (k % 5) @(negedge src_clk);
    end

    for (int t = 0; t < 200 && (expq.size() != 0 || !src_ready); t++) @(negedge src_clk);
    repeat (20) @(negedge dst_clk);
    check(expq.size() == 0, "R6 none lost", W'(expq.size()), '0);
    check(delivered == launched, "R4 once each", W'(delivered), W'(launched));
    check(src_ready == 1, "R2 ready returns", {15'd0, src_ready}, 16'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule